// File: doc/BRIEF.md
# Vintage Computer Video Capture

This block turns the raw digital video of an old home computer into writes on the write port of a 1-bit dual-port framebuffer. The block runs on the host's own dot clock. It takes the host's horizontal sync, vertical sync and serial pixel bit, and counts dots along each line and lines down each frame to form a linear write address. At most `H_PIXELS` pixels per line and `V_LINES` lines per frame are stored. A display engine on the other port of the RAM reads the picture out at its own pace. The RAM and that display side are outside this block.

The host can switch between a narrow and a wide text mode, and the two modes use different dot clocks. The block therefore measures the longest line of every frame at each vertical sync and compares it with the previous frame's figure. A narrow-mode line writes fewer columns than a wide-mode line, so pixels from the wide mode would remain at the edges of the buffer. When the measured length moves by more than a tolerance, the block spends the following frame sweeping zeros through every location of the buffer. Normal capture returns at the next vertical sync.

Top module: `video_capture`

## Requirements
- R1: Reset drives `fb_we` low. No write occurs until a rising edge of `host_vsync` has been seen, and `host_hsync` edges that arrive before that produce no writes.
- R2: All host inputs are active high and are sampled on `clk`. Column 0 of a line holds the `host_video` value sampled on the same edge that first samples `host_hsync` high. Each later dot lands in the next column.
- R3: The first `host_hsync` rising edge after a `host_vsync` rising edge starts row 0, and each later one starts the next row. Rows at or beyond `V_LINES` are never written.
- R4: A capture write occurs only while the column is below `H_PIXELS`. Its address is row*`H_PIXELS` + column and its data is the pixel bit.
- R5: A line's length is the number of dots between two successive `host_hsync` rising edges inside a frame. The longest line of a frame is latched at the next `host_vsync` rising edge. The first latched length after reset is only stored and never starts a clear.
- R6: If the newly latched length differs from the previously latched one by more than `LEN_TOL` dots, the frame that follows is a clear frame. A difference of `LEN_TOL` or less leaves capture running.
- R7: In a clear frame the block writes data 0 to every address from 0 to `H_PIXELS`*`V_LINES`-1, one per cycle, in ascending order, each exactly once. No capture write occurs in that frame.
- R8: Capture resumes at the `host_vsync` rising edge that ends the clear frame. Columns that a shorter line does not reach keep their previous contents unless a clear has removed them.
- R9: A sync pulse that stays high for several dots counts as a single edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host dot clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| host_hsync | input | 1 | Host horizontal sync, active high |
| host_vsync | input | 1 | Host vertical sync, active high |
| host_video | input | 1 | Host serial pixel bit |
| fb_we | output | 1 | Framebuffer write enable |
| fb_addr | output | $clog2(H_PIXELS*V_LINES) | Framebuffer write address |
| fb_wdata | output | 1 | Framebuffer write data |

## Verification
The assertions check the following on every cycle:
- Each sync edge lasts a single cycle.
- Every write address stays inside the buffer.
- A clear frame writes only zeros, to addresses that climb by one.
- No write happens before frame lock.
- A line length equal to the stored one never flags a mode change.

Some behaviour only the bench scenarios can show:
- Whether a given pixel lands in the right column and row.
- Whether a narrower mode leaves old pixels at the edges.
- Whether a change in line length just above or just below the tolerance starts a clear.

The bench covers these by modelling the framebuffer from the observed writes and comparing it after each frame.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;

    // Width of the dot counter; lines longer than 2**LEN_W-1 dots saturate.
    localparam int LEN_W = 11;

    typedef logic [LEN_W-1:0] len_t;

    // Raw host signals as they arrive.
    typedef struct packed {
        logic hs;
        logic vs;
        logic px;
    } host_in_t;

    // Synchronised events and aligned pixel.
    typedef struct packed {
        logic h_edge;
        logic v_edge;
        logic pixel;
    } host_evt_t;

    function automatic len_t len_gap(input len_t a, input len_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/cap_sync.sv
`timescale 1ns/1ps
module cap_sync
    import cap_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  host_in_t  raw,
    output host_evt_t evt
);

    logic [STAGES-1:0] hs_q;
    logic [STAGES-1:0] vs_q;
    logic [STAGES:0]   px_q;   // one stage longer than the syncs
    logic              hs_last;
    logic              vs_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q    <= '0;
            vs_q    <= '0;
            px_q    <= '0;
            hs_last <= 1'b0;
            vs_last <= 1'b0;
        end else begin
            hs_q    <= {hs_q[STAGES-2:0], raw.hs};
            vs_q    <= {vs_q[STAGES-2:0], raw.vs};
            px_q    <= {px_q[STAGES-1:0], raw.px};
            hs_last <= hs_q[STAGES-1];
            vs_last <= vs_q[STAGES-1];
        end
    end

    assign evt.h_edge = hs_q[STAGES-1] & ~hs_last;
    assign evt.v_edge = vs_q[STAGES-1] & ~vs_last;
    assign evt.pixel  = px_q[STAGES];

    AST_HEDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        evt.h_edge |=> !evt.h_edge);  // R9
    AST_VEDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        evt.v_edge |=> !evt.v_edge);  // R9

endmodule

// File: rtl/cap_counters.sv
`timescale 1ns/1ps
module cap_counters
    import cap_pkg::*;
#(
    parameter  int H_PIXELS = 640,
    parameter  int V_LINES  = 240,
    localparam int ROW_W    = $clog2(V_LINES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  host_evt_t        evt,
    output len_t             col,
    output logic [ROW_W-1:0] row,
    output logic             in_frame,
    output len_t             line_max,
    output logic             capture_ok
);

    localparam logic [ROW_W-1:0] ROW_IDLE = ROW_W'(V_LINES);

    logic first_line;
    len_t len_now;

    assign len_now = (col == '1) ? col : col + LEN_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            col        <= '1;
            row        <= ROW_IDLE;
            first_line <= 1'b0;
            in_frame   <= 1'b0;
            line_max   <= '0;
        end else begin
            if (evt.h_edge) begin
                col <= '0;
            end else if (col != '1) begin
                col <= col + LEN_W'(1);
            end

            if (evt.v_edge) begin
                row        <= ROW_IDLE;
                first_line <= 1'b1;
                in_frame   <= 1'b1;
                line_max   <= '0;
            end else if (evt.h_edge) begin
                if (first_line) begin
                    row        <= '0;
                    first_line <= 1'b0;
                end else begin
                    if (row != ROW_IDLE) begin
                        row <= row + ROW_W'(1);
                    end
                    if (in_frame && (len_now > line_max)) begin
                        line_max <= len_now;
                    end
                end
            end
        end
    end

    assign capture_ok = (col < LEN_W'(H_PIXELS)) && (row < ROW_IDLE);

endmodule

// File: rtl/cap_mode_det.sv
`timescale 1ns/1ps
module cap_mode_det
    import cap_pkg::*;
#(
    parameter int LEN_TOL = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic v_edge,
    input  logic in_frame,
    input  len_t line_max,
    output logic mode_change
);

    len_t ref_len;
    logic ref_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_len <= '0;
            ref_ok  <= 1'b0;
        end else if (v_edge && in_frame) begin
            ref_len <= line_max;
            ref_ok  <= 1'b1;
        end
    end

    assign mode_change = v_edge && in_frame && ref_ok &&
                         (len_gap(line_max, ref_len) > LEN_W'(LEN_TOL));

    AST_SAME_LEN_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (v_edge && ref_ok && (line_max == ref_len)) |-> !mode_change);  // R6

endmodule

// File: rtl/cap_clear.sv
`timescale 1ns/1ps
module cap_clear #(
    parameter  int DEPTH  = 153600,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              v_edge,
    input  logic              mode_change,
    output logic              clr_active,
    output logic              sweep_we,
    output logic [ADDR_W-1:0] sweep_addr
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_active <= 1'b0;
            sweep_we   <= 1'b0;
            sweep_addr <= '0;
        end else if (v_edge) begin
            clr_active <= mode_change;
            sweep_we   <= mode_change;
            sweep_addr <= '0;
        end else if (sweep_we) begin
            if (sweep_addr == LAST) begin
                sweep_we <= 1'b0;
            end else begin
                sweep_addr <= sweep_addr + ADDR_W'(1);
            end
        end
    end

endmodule

// File: rtl/video_capture.sv
`timescale 1ns/1ps
module video_capture
    import cap_pkg::*;
#(
    parameter  int H_PIXELS    = 640,
    parameter  int V_LINES     = 240,
    parameter  int LEN_TOL     = 4,
    parameter  int SYNC_STAGES = 2,
    localparam int DEPTH       = H_PIXELS * V_LINES,
    localparam int ADDR_W      = $clog2(DEPTH),
    localparam int ROW_W       = $clog2(V_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_hsync,
    input  logic              host_vsync,
    input  logic              host_video,
    output logic              fb_we,
    output logic [ADDR_W-1:0] fb_addr,
    output logic              fb_wdata
);

    host_in_t          raw;
    host_evt_t         evt;
    len_t              col;
    len_t              line_max;
    logic [ROW_W-1:0]  row;
    logic              in_frame;
    logic              capture_ok;
    logic              mode_change;
    logic              clr_active;
    logic              sweep_we;
    logic [ADDR_W-1:0] sweep_addr;
    logic [ADDR_W-1:0] cap_addr;

    assign raw = '{hs: host_hsync, vs: host_vsync, px: host_video};

    cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .raw (raw),
        .evt (evt)
    );

    cap_counters #(.H_PIXELS(H_PIXELS), .V_LINES(V_LINES)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .col        (col),
        .row        (row),
        .in_frame   (in_frame),
        .line_max   (line_max),
        .capture_ok (capture_ok)
    );

    cap_mode_det #(.LEN_TOL(LEN_TOL)) u_mode (
        .clk         (clk),
        .rst         (rst),
        .v_edge      (evt.v_edge),
        .in_frame    (in_frame),
        .line_max    (line_max),
        .mode_change (mode_change)
    );

    cap_clear #(.DEPTH(DEPTH)) u_clr (
        .clk         (clk),
        .rst         (rst),
        .v_edge      (evt.v_edge),
        .mode_change (mode_change),
        .clr_active  (clr_active),
        .sweep_we    (sweep_we),
        .sweep_addr  (sweep_addr)
    );

    assign cap_addr = ADDR_W'(row) * ADDR_W'(H_PIXELS) + ADDR_W'(col);

    always_comb begin
        if (clr_active) begin
            fb_we    = sweep_we;
            fb_addr  = sweep_addr;
            fb_wdata = 1'b0;
        end else begin
            fb_we    = capture_ok;
            fb_addr  = cap_addr;
            fb_wdata = evt.pixel;
        end
    end

    AST_NO_LOCK_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !in_frame |-> !fb_we);  // R1
    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> (fb_addr <= ADDR_W'(DEPTH - 1)));  // R4
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (fb_we && clr_active) |-> !fb_wdata);  // R7
    AST_SWEEP_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (fb_we && clr_active && $past(fb_we && clr_active) && !$past(evt.v_edge))
        |-> (fb_addr == $past(fb_addr) + ADDR_W'(1)));  // R7

endmodule

// File: tb/video_capture_tb.sv
`timescale 1ns/1ps
module video_capture_tb;

    localparam int H     = 40;
    localparam int V     = 6;
    localparam int TOL   = 4;
    localparam int DEPTH = H * V;
    localparam int AW    = $clog2(DEPTH);
    localparam int NL    = 10;   // host lines per frame (more than V)
    localparam int NVEC  = 10;

    // {line length in dots, clear frame expected}; the pixel seed is index+1
    localparam int VEC [NVEC][2] = '{
        '{48, 0}, '{48, 0}, '{32, 0}, '{32, 1}, '{32, 0},
        '{34, 0}, '{34, 0}, '{48, 0}, '{48, 1}, '{48, 0}
    };

    logic clk = 1'b0;
    logic rst;
    logic hs, vs, vid;
    logic fb_we;
    logic [AW-1:0] fb_addr;
    logic fb_wdata;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;

    logic mdl  [DEPTH];
    logic refm [DEPTH];
    int   f_wr;
    int   f_ones;
    bit   f_seq;

    always #2.5 clk = ~clk;

    video_capture #(.H_PIXELS(H), .V_LINES(V), .LEN_TOL(TOL)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .host_hsync (hs),
        .host_vsync (vs),
        .host_video (vid),
        .fb_we      (fb_we),
        .fb_addr    (fb_addr),
        .fb_wdata   (fb_wdata)
    );

    // Framebuffer model fed by the observed writes, sampled mid-cycle.
    always @(negedge clk) begin
        if (!rst && fb_we) begin
            mdl[fb_addr] = fb_wdata;
            if (int'(fb_addr) != f_wr) f_seq = 0;
            f_wr++;
            if (fb_wdata) f_ones++;
        end
    end

    function automatic logic pat(input int s, input int l, input int d);
        return (((d * 5 + l * 11 + s * 13) / 3) % 2) == 1;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic run_frame(input int len, input int seed);
        f_wr = 0; f_ones = 0; f_seq = 1;
        for (int i = 0; i < 6; i++) begin
            step(); hs = 1'b0; vid = 1'b0; vs = (i < 2);
        end
        for (int l = 0; l < NL; l++) begin
            for (int d = 0; d < len; d++) begin
                step(); vs = 1'b0; hs = (d < 3); vid = pat(seed, l, d);
            end
        end
        step(); hs = 1'b0; vid = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mdl[i]  = 1'b0;
            refm[i] = 1'b0;
        end
        f_wr = 0; f_ones = 0; f_seq = 1;
        rst = 1'b1; hs = 1'b0; vs = 1'b0; vid = 1'b0;
        repeat (4) step();
        check(fb_we == 1'b0, "R1 write enable low in reset", int'(fb_we), 0);
        rst = 1'b0;
        step();
        check(fb_we == 1'b0, "R1 write enable low after reset", int'(fb_we), 0);

        // R1: lines with no frame sync yet must not write anything
        f_wr = 0;
        for (int l = 0; l < 3; l++) begin
            for (int d = 0; d < 48; d++) begin
                step(); hs = (d < 3); vid = 1'b1;
            end
        end
        step(); hs = 1'b0; vid = 1'b0;
        check(f_wr == 0, "R1 no write before first vsync", f_wr, 0);

        for (int v = 0; v < NVEC; v++) begin
            int len;
            bit clr;
            int mism;
            int exp_wr;
            bit clear_seen;
            int wmax;
            len  = VEC[v][0];
            clr  = (VEC[v][1] != 0);
            run_frame(len, v + 1);

            wmax = (len < H) ? len : H;
            if (clr) begin
                for (int i = 0; i < DEPTH; i++) refm[i] = 1'b0;
            end else begin
                for (int r = 0; r < V; r++)
                    for (int c = 0; c < wmax; c++)
                        refm[r * H + c] = pat(v + 1, r, c);
            end
            mism = 0;
            for (int i = 0; i < DEPTH; i++)
                if (mdl[i] !== refm[i]) mism++;

            clear_seen = (f_wr == DEPTH) && (f_ones == 0) && f_seq;
            if (clr) begin
                check(mism == 0, "R7 R8 buffer cleared", mism, 0);
                check(clear_seen, "R6 clear frame started", f_wr, DEPTH);
            end else begin
                // R2 R8: pixel alignment and stale columns kept in narrow mode
                check(mism == 0, "R2 R8 captured picture", mism, 0);
                exp_wr = V * wmax;
                check(f_wr == exp_wr, "R3 R4 R9 capture write count", f_wr, exp_wr);
                check(f_ones > 0 && !clear_seen, "R5 R6 no clear", f_ones, 1);
            end
        end
        finish_run();
    end

endmodule